// File: doc/BRIEF.md
# Reset Sequence Controller

This block gathers every reason a small 8-bit processor may need to restart and turns it into a single, well-ordered restart sequence. There are four requesters: a reset pad that outside circuitry can pull low, a supply-voltage monitor, a watchdog and the decoder's illegal-instruction trap. Each one starts the same three-step flow. First comes a hold step whose length depends on the requester. Next comes a start-up wait that lets the oscillator settle. Last comes a two-cycle window in which the processor reads its restart vector from the top two bytes of memory.

The reset pad is open-drain. The block can pull it low and can let it go, but it never drives it high. The block holds the pad low through the hold step, the start-up wait and any extra PLL lock wait, so chips that share the pad see the restart too. A two-bit clock-source setting selects a short or a long start-up wait. When the PLL is enabled, release waits further for the PLL to lock. A pull on the pad is also sent straight out, with no clock involved, as a wake request. This lets a halted part whose clock is stopped start its clock again and then qualify the pulse.

Top module: `rstseq_ctrl`

## Requirements
- R1: While `rst` is high, `rst_pad_oe_o` and `cpu_rst_o` are 1 and `vec_fetch_o` is 0. After `rst` falls, the pad stays pulled low for ACT_INT plus the selected start-up wait, counted from the first cycle after release, and `rst_cause_o` reads 0 (power-on).
- R2: A high level in any clock cycle on `lvd_rst_i`, `wdg_rst_i` or `illop_rst_i` starts a sequence whose pull-low window lasts ACT_INT plus the start-up wait. `rst_cause_o` then reads 2, 3 or 4 respectively.
- R3: The steps always run in this order: pad pulled low with `cpu_rst_o` high, then exactly two cycles with `vec_fetch_o` high, the pad released and `cpu_rst_o` low, with `vec_addr_o` showing 16'hFFFE (high byte) and then 16'hFFFF (low byte). After that `vec_fetch_o` is 0 and the pad stays released.
- R4: A `clk_src_i` value of 0 (internal RC) or 1 (external clock input) selects DLY_SHORT cycles. A value of 2 or 3 (crystal or ceramic resonator) selects DLY_LONG cycles. The setting is sampled when the start-up wait begins.
- R5: When `pll_en_i` is 1, PLL_LOCK more pull-low cycles follow the start-up wait before the vector fetch.
- R6: An external low on `rst_pad_i` is accepted only if it lasts at least MIN_W synchronised samples. An accepted pulse gives cause 1 and a hold step of ACT_EXT cycles. A shorter pulse leaves the pad released and the processor running.
- R7: While the block itself pulls the pad low, and for SYNC_STAGES+1 cycles after it lets go, the sampled pad level is ignored. An outside pull during that time neither lengthens nor restarts the sequence and does not change the cause.
- R8: A new request in any step, including the vector fetch, restarts the hold step in the next cycle. The full pull-low window is counted again from there.
- R9: When requests arrive in the same cycle, the recorded cause follows the priority external, then voltage monitor, then watchdog, then illegal instruction.
- R10: `clk_wake_o` is high, with no clock needed, whenever the pad is low and the block is not pulling it low itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| rst_pad_i | input | 1 | Level read back from the reset pad |
| rst_pad_oe_o | output | 1 | 1 pulls the open-drain pad low, 0 releases it |
| lvd_rst_i | input | 1 | Reset request from the supply-voltage monitor |
| wdg_rst_i | input | 1 | Reset request from the watchdog |
| illop_rst_i | input | 1 | Reset request from the illegal-instruction trap |
| clk_src_i | input | 2 | Clock-source setting: 0 RC, 1 external clock, 2/3 resonator |
| pll_en_i | input | 1 | PLL enabled, which adds the lock wait |
| cpu_rst_o | output | 1 | Holds the CPU core in reset |
| vec_fetch_o | output | 1 | CPU reads the restart vector this cycle |
| vec_addr_o | output | 16 | Address of the vector byte being read |
| rst_cause_o | output | 3 | Source of the latest reset (0 POR, 1 pin, 2 LVD, 3 WDG, 4 illegal op) |
| clk_wake_o | output | 1 | Unclocked wake request while the pad is pulled externally |

## Verification
The bench builds the block with ACT_INT=3, ACT_EXT=6, DLY_SHORT=16, DLY_LONG=48, PLL_LOCK=10, MIN_W=4 and SYNC_STAGES=2. With these values every pull-low window can be counted cycle by cycle in a few dozen clocks, and the short, long and PLL-extended waits give three clearly different totals. Because MIN_W is small, pulses one sample below and exactly at the acceptance width can both be tried. Because the short wait outlasts an eight-cycle outside pull, such a pull can land fully inside the block's own drive and must leave no trace.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [2:0] {
    CAUSE_POR = 3'd0,
    CAUSE_EXT = 3'd1,
    CAUSE_LVD = 3'd2,
    CAUSE_WDG = 3'd3,
    CAUSE_ILL = 3'd4
  } cause_e;

  typedef enum logic [2:0] {
    PH_ACTIVE   = 3'd0,
    PH_DELAY    = 3'd1,
    PH_PLL      = 3'd2,
    PH_FETCH_HI = 3'd3,
    PH_FETCH_LO = 3'd4,
    PH_RUN      = 3'd5
  } phase_e;

  localparam int NUM_SRC = 4;

  // Clock-source code with bit 1 set means a resonator: long settle time.
  function automatic logic needs_long_settle(input logic [1:0] src);
    return src[1];
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rstseq_pinfilt.sv
module rstseq_pinfilt #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_W       = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic pad_i,
  input  logic drive_i,
  output logic ext_req_o,
  output logic wake_o
);
  localparam int WCNT_W = $clog2(MIN_W + 1);
  localparam int MASK_N = SYNC_STAGES + 1;
  localparam int MASK_W = $clog2(MASK_N + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [MASK_W-1:0]      mask_cnt;
  logic [WCNT_W-1:0]      low_cnt;
  logic                   ext_req_q;
  logic                   masked;
  logic                   pad_low;

  // Synchroniser chain, one flop per stage
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) sync_q[g] <= 1'b1;
      else if (g == 0) sync_q[g] <= pad_i;
      else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
    end
  end

  assign pad_low = ~sync_q[SYNC_STAGES-1];

  // Blind the filter while this block pulls the pad, plus the pipeline tail
  always_ff @(posedge clk) begin
    if (rst)                mask_cnt <= MASK_W'(MASK_N);
    else if (drive_i)       mask_cnt <= MASK_W'(MASK_N);
    else if (mask_cnt != 0) mask_cnt <= mask_cnt - 1'b1;
  end

  assign masked = drive_i || (mask_cnt != '0);

  // Minimum-width qualifier with one-shot output
  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt   <= '0;
      ext_req_q <= 1'b0;
    end else begin
      if (masked || !pad_low)              low_cnt <= '0;
      else if (low_cnt != WCNT_W'(MIN_W))  low_cnt <= low_cnt + 1'b1;
      ext_req_q <= !masked && pad_low && (low_cnt == WCNT_W'(MIN_W - 1));
    end
  end

  assign ext_req_o = ext_req_q;
  // Unclocked path: must work while the clock is stopped
  assign wake_o    = ~pad_i & ~drive_i;

  AST_EXT_ONESHOT: assert property (@(posedge clk) disable iff (rst)
    ext_req_o |=> !ext_req_o); // R6
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (rst)
    drive_i |=> !ext_req_o); // R7

endmodule

// File: rtl/rstseq_arb.sv
module rstseq_arb
  import rstseq_pkg::*;
(
  input  logic   ext_i,
  input  logic   lvd_i,
  input  logic   wdg_i,
  input  logic   ill_i,
  output logic   req_o,
  output cause_e cause_o
);
  logic [NUM_SRC-1:0] reqs;
  logic [2:0]         win;

  // Index 0 wins: external, voltage monitor, watchdog, illegal op
  assign reqs = {ill_i, wdg_i, lvd_i, ext_i};

  always_comb begin
    win = 3'd0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (reqs[i]) win = 3'(i);
    end
  end

  assign req_o   = |reqs;
  assign cause_o = cause_e'(3'(CAUSE_EXT) + win);

endmodule

// File: rtl/rstseq_seq.sv
module rstseq_seq
  import rstseq_pkg::*;
#(
  parameter int ACT_INT   = 4,
  parameter int ACT_EXT   = 8,
  parameter int DLY_SHORT = 256,
  parameter int DLY_LONG  = 4096,
  parameter int PLL_LOCK  = 512,
  parameter int ADDR_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  cause_e            cause_i,
  input  logic [1:0]        clk_src_i,
  input  logic              pll_en_i,
  output logic              pad_oe_o,
  output logic              cpu_rst_o,
  output logic              vec_fetch_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output cause_e            cause_o
);
  localparam int MAX_LEN = max2(max2(ACT_INT, ACT_EXT), max2(max2(DLY_SHORT, DLY_LONG), PLL_LOCK));
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam int MAX_HOLD = max2(ACT_INT, ACT_EXT) + max2(DLY_SHORT, DLY_LONG) + PLL_LOCK;
  localparam int HOLD_W  = $clog2(MAX_HOLD + 2);
  localparam logic [ADDR_W-1:0] VEC_LO = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] VEC_HI = VEC_LO - 1'b1;

  phase_e           st, st_d;
  logic [CNT_W-1:0] cnt, cnt_d;
  logic             hold_d;
  logic             fetch_d;

  always_comb begin
    st_d  = st;
    cnt_d = cnt;
    if (req_i) begin
      st_d  = PH_ACTIVE;
      cnt_d = (cause_i == CAUSE_EXT) ? CNT_W'(ACT_EXT - 1) : CNT_W'(ACT_INT - 1);
    end else begin
      case (st)
        PH_ACTIVE: begin
          if (cnt == '0) begin
            st_d  = PH_DELAY;
            cnt_d = needs_long_settle(clk_src_i) ? CNT_W'(DLY_LONG - 1) : CNT_W'(DLY_SHORT - 1);
          end else cnt_d = cnt - 1'b1;
        end
        PH_DELAY: begin
          if (cnt == '0) begin
            if (pll_en_i) begin
              st_d  = PH_PLL;
              cnt_d = CNT_W'(PLL_LOCK - 1);
            end else st_d = PH_FETCH_HI;
          end else cnt_d = cnt - 1'b1;
        end
        PH_PLL: begin
          if (cnt == '0) st_d = PH_FETCH_HI;
          else cnt_d = cnt - 1'b1;
        end
        PH_FETCH_HI: st_d = PH_FETCH_LO;
        PH_FETCH_LO: st_d = PH_RUN;
        PH_RUN:      st_d = PH_RUN;
        default:     st_d = PH_ACTIVE;
      endcase
    end
  end

  assign hold_d  = (st_d == PH_ACTIVE) || (st_d == PH_DELAY) || (st_d == PH_PLL);
  assign fetch_d = (st_d == PH_FETCH_HI) || (st_d == PH_FETCH_LO);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= PH_ACTIVE;
      cnt         <= CNT_W'(ACT_INT - 1);
      pad_oe_o    <= 1'b1;
      cpu_rst_o   <= 1'b1;
      vec_fetch_o <= 1'b0;
      vec_addr_o  <= VEC_HI;
      cause_o     <= CAUSE_POR;
    end else begin
      st          <= st_d;
      cnt         <= cnt_d;
      pad_oe_o    <= hold_d;
      cpu_rst_o   <= hold_d;
      vec_fetch_o <= fetch_d;
      vec_addr_o  <= (st_d == PH_FETCH_LO) ? VEC_LO : VEC_HI;
      if (req_i) cause_o <= cause_i;
    end
  end

  // Checker-side window counter: cycles held low since the last request
  logic [HOLD_W-1:0] hold_run;
  always_ff @(posedge clk) begin
    if (rst || req_i)  hold_run <= '0;
    else if (pad_oe_o) hold_run <= hold_run + 1'b1;
    else               hold_run <= '0;
  end

  AST_FETCH_AFTER_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(vec_fetch_o) |-> $past(pad_oe_o)); // R3
  AST_FETCH_ORDER: assert property (@(posedge clk) disable iff (rst)
    (vec_fetch_o && vec_addr_o == VEC_HI && !req_i) |=> (vec_fetch_o && vec_addr_o == VEC_LO)); // R3
  AST_NO_DRIVE_IN_FETCH: assert property (@(posedge clk) disable iff (rst)
    !(pad_oe_o && vec_fetch_o)); // R3
  AST_RUN_STAYS: assert property (@(posedge clk) disable iff (rst)
    (!pad_oe_o && !vec_fetch_o && !req_i) |=> (!pad_oe_o && !cpu_rst_o)); // R3
  AST_REQ_RESTART: assert property (@(posedge clk) disable iff (rst)
    req_i |=> (pad_oe_o && cpu_rst_o && !vec_fetch_o)); // R8
  AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (rst)
    hold_run <= HOLD_W'(MAX_HOLD)); // R4

endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
  import rstseq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_W       = 20,
  parameter int ACT_INT     = 4,
  parameter int ACT_EXT     = 8,
  parameter int DLY_SHORT   = 256,
  parameter int DLY_LONG    = 4096,
  parameter int PLL_LOCK    = 512
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rst_pad_i,
  output logic        rst_pad_oe_o,
  input  logic        lvd_rst_i,
  input  logic        wdg_rst_i,
  input  logic        illop_rst_i,
  input  logic [1:0]  clk_src_i,
  input  logic        pll_en_i,
  output logic        cpu_rst_o,
  output logic        vec_fetch_o,
  output logic [15:0] vec_addr_o,
  output logic [2:0]  rst_cause_o,
  output logic        clk_wake_o
);
  logic   ext_req;
  logic   any_req;
  cause_e win_cause;
  cause_e cause_q;

  rstseq_pinfilt #(
    .SYNC_STAGES (SYNC_STAGES),
    .MIN_W       (MIN_W)
  ) u_pinfilt (
    .clk       (clk),
    .rst       (rst),
    .pad_i     (rst_pad_i),
    .drive_i   (rst_pad_oe_o),
    .ext_req_o (ext_req),
    .wake_o    (clk_wake_o)
  );

  rstseq_arb u_arb (
    .ext_i   (ext_req),
    .lvd_i   (lvd_rst_i),
    .wdg_i   (wdg_rst_i),
    .ill_i   (illop_rst_i),
    .req_o   (any_req),
    .cause_o (win_cause)
  );

  rstseq_seq #(
    .ACT_INT   (ACT_INT),
    .ACT_EXT   (ACT_EXT),
    .DLY_SHORT (DLY_SHORT),
    .DLY_LONG  (DLY_LONG),
    .PLL_LOCK  (PLL_LOCK),
    .ADDR_W    (16)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .req_i       (any_req),
    .cause_i     (win_cause),
    .clk_src_i   (clk_src_i),
    .pll_en_i    (pll_en_i),
    .pad_oe_o    (rst_pad_oe_o),
    .cpu_rst_o   (cpu_rst_o),
    .vec_fetch_o (vec_fetch_o),
    .vec_addr_o  (vec_addr_o),
    .cause_o     (cause_q)
  );

  assign rst_cause_o = cause_q;

  AST_EXT_WINS: assert property (@(posedge clk) disable iff (rst)
    (ext_req && (lvd_rst_i || wdg_rst_i || illop_rst_i)) |=> (rst_cause_o == 3'd1)); // R9
  AST_LVD_OVER_WDG: assert property (@(posedge clk) disable iff (rst)
    (!ext_req && lvd_rst_i) |=> (rst_cause_o == 3'd2)); // R9
  AST_WAKE_WHILE_HELD: assert property (@(posedge clk) disable iff (rst)
    rst_pad_oe_o |-> !clk_wake_o); // R10

endmodule

// File: tb/rstseq_ctrl_test.sv
`timescale 1ns/1ps
module rstseq_ctrl_test;
  localparam int ACT_INT = 3, ACT_EXT = 6, DLY_S = 16, DLY_L = 48, PLL_N = 10, MIN_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_low = 1'b0;
  logic lvd = 1'b0, wdg = 1'b0, ill = 1'b0;
  logic [1:0] csrc = 2'd0;
  logic pll = 1'b0;
  logic pad, oe, cpu_rst, fetch, wake;
  logic [15:0] addr;
  logic [2:0] cause;
  int n_tests = 0, n_fail = 0, cycles = 0;

  always #2.5 clk = ~clk;
  assign pad = (ext_low || oe) ? 1'b0 : 1'b1;

  rstseq_ctrl #(.SYNC_STAGES(2), .MIN_W(MIN_W), .ACT_INT(ACT_INT), .ACT_EXT(ACT_EXT),
                .DLY_SHORT(DLY_S), .DLY_LONG(DLY_L), .PLL_LOCK(PLL_N)) uut (
    .clk(clk), .rst(rst), .rst_pad_i(pad), .rst_pad_oe_o(oe),
    .lvd_rst_i(lvd), .wdg_rst_i(wdg), .illop_rst_i(ill),
    .clk_src_i(csrc), .pll_en_i(pll), .cpu_rst_o(cpu_rst),
    .vec_fetch_o(fetch), .vec_addr_o(addr), .rst_cause_o(cause), .clk_wake_o(wake));

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // Counts pull-low cycles starting at the current falling edge
  task automatic hold_len(output int n);
    n = 0;
    while (!oe) @(negedge clk);
    while (oe) begin n++; @(negedge clk); end
  endtask

  // Called on the first falling edge after release
  task automatic tail(input string rq);
    chk(fetch && !cpu_rst && addr == 16'hFFFE, rq, int'(addr), 16'hFFFE);
    @(negedge clk);
    chk(fetch && !oe && addr == 16'hFFFF, rq, int'(addr), 16'hFFFF);
    @(negedge clk);
    chk(!fetch && !cpu_rst && !oe && pad, rq, int'(fetch), 0);
  endtask

  task automatic pulse(input bit l, input bit w, input bit i);
    @(negedge clk); lvd = l; wdg = w; ill = i;
    @(negedge clk); lvd = 0; wdg = 0; ill = 0;
  endtask

  task automatic t_por();
    int n;
    repeat (3) @(negedge clk);
    chk(oe && cpu_rst && !fetch, "R1 held", int'(oe), 1);
    rst = 1'b0;
    hold_len(n);
    chk(n == ACT_INT + DLY_S, "R1 length", n, ACT_INT + DLY_S);
    tail("R3 after POR");
    chk(cause == 3'd0, "R1 cause", int'(cause), 0);
  endtask

  task automatic t_internal(input bit l, input bit w, input bit i, input int ec, input string rq);
    int n;
    pulse(l, w, i);
    hold_len(n);
    chk(n == ACT_INT + DLY_S, rq, n, ACT_INT + DLY_S);
    tail("R3 tail");
    chk(cause == 3'(ec), rq, int'(cause), ec);
  endtask

  task automatic t_src(input logic [1:0] s, input bit p, input int exp, input string rq);
    int n;
    csrc = s; pll = p;
    pulse(0, 1, 0);
    hold_len(n);
    chk(n == exp, rq, n, exp);
    tail(rq);
    csrc = 2'd0; pll = 1'b0;
  endtask

  task automatic t_ext_glitch();
    bit seen = 0;
    @(negedge clk); ext_low = 1'b1;
    repeat (MIN_W - 1) @(negedge clk);
    ext_low = 1'b0;
    repeat (20) begin @(negedge clk); if (oe || cpu_rst) seen = 1; end
    chk(!seen, "R6 short pulse ignored", int'(seen), 0);
  endtask

  task automatic t_ext();
    int n, w = 0;
    @(negedge clk); ext_low = 1'b1;
    while (!oe && w < 40) begin @(negedge clk); w++; end
    ext_low = 1'b0;
    hold_len(n);
    chk(n == ACT_EXT + DLY_S, "R6 pin sequence", n, ACT_EXT + DLY_S);
    tail("R6 tail");
    chk(cause == 3'd1, "R6 cause", int'(cause), 1);
  endtask

  task automatic t_masked();
    int n = 0;
    pulse(1, 0, 0);
    repeat (5) begin n++; @(negedge clk); end
    ext_low = 1'b1;
    repeat (8) begin n++; @(negedge clk); end
    ext_low = 1'b0;
    while (oe) begin n++; @(negedge clk); end
    chk(n == ACT_INT + DLY_S, "R7 own-drive pull ignored", n, ACT_INT + DLY_S);
    tail("R7 tail");
    chk(cause == 3'd2, "R7 cause kept", int'(cause), 2);
    repeat (6) @(negedge clk);
    chk(!oe, "R7 no late restart", int'(oe), 0);
  endtask

  task automatic t_restart();
    int n;
    pulse(1, 0, 0);
    repeat (10) @(negedge clk);
    wdg = 1'b1; @(negedge clk); wdg = 1'b0;
    hold_len(n);
    chk(n == ACT_INT + DLY_S, "R8 restart in delay", n, ACT_INT + DLY_S);
    chk(fetch && cause == 3'd3, "R8 cause wdg", int'(cause), 3);
    ill = 1'b1; @(negedge clk); ill = 1'b0;
    chk(oe && !fetch && cpu_rst, "R8 restart in fetch", int'(oe), 1);
    hold_len(n);
    chk(n == ACT_INT + DLY_S, "R8 full window again", n, ACT_INT + DLY_S);
    tail("R8 tail");
    chk(cause == 3'd4, "R8 cause ill", int'(cause), 4);
  endtask

  task automatic t_wake();
    @(negedge clk); ext_low = 1'b1; #1;
    chk(wake == 1'b1, "R10 wake on pad low", int'(wake), 1);
    ext_low = 1'b0; #1;
    chk(wake == 1'b0, "R10 wake clears", int'(wake), 0);
    pulse(1, 0, 0); #1;
    chk(oe && !wake, "R10 own drive no wake", int'(wake), 0);
    while (oe) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    while (cycles < 100000) begin @(posedge clk); cycles++; end
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_por();
    t_internal(1, 0, 0, 2, "R2 lvd");
    t_internal(0, 1, 0, 3, "R2 wdg");
    t_internal(0, 0, 1, 4, "R2 ill");
    t_src(2'd1, 0, ACT_INT + DLY_S, "R4 ext clock short");
    t_src(2'd2, 0, ACT_INT + DLY_L, "R4 resonator long");
    t_src(2'd3, 0, ACT_INT + DLY_L, "R4 code 3 long");
    t_src(2'd0, 1, ACT_INT + DLY_S + PLL_N, "R5 pll short");
    t_src(2'd2, 1, ACT_INT + DLY_L + PLL_N, "R5 pll long");
    t_ext_glitch();
    t_ext();
    t_masked();
    t_restart();
    t_internal(1, 1, 1, 2, "R9 lvd wins");
    t_internal(0, 1, 1, 3, "R9 wdg over ill");
    t_wake();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule